// File: doc/BRIEF.md
# Load-Reserved Store-Conditional Monitor

This block is a small shared word memory with a reservation monitor beside it. Several requesters present requests at once. A fixed-priority arbiter picks one of them each cycle, and that request is carried out against the memory in the same cycle.

There are four operations: a plain load, a plain store, a load-reserved and a store-conditional. A load-reserved returns the word and records a reservation for that requester on that address. A store-conditional writes only if that requester still holds a reservation on the same address. The requester learns from a status flag whether the store-conditional took effect.

Nothing is ever locked. The monitor only detects whether the read and write pair would have looked indivisible. A reservation is dropped when any write lands on the reserved address, or when an eviction pulse names that address. A requester whose store-conditional fails simply retries.

Top module: `llsc_monitor`

## Requirements
- R1: After reset, `rsp_vld` is all zero and every memory word reads as zero. No requester holds a reservation, so a store-conditional issued straight after reset fails.
- R2: Whenever at least one request is pending, exactly one `gnt` bit is set in that same cycle, and it belongs to a requesting port. Held reservations never stall any request.
- R3: One cycle after a grant, the `rsp_vld` bit of the granted requester is high for exactly one cycle. `rsp_rdata` carries the word held before that cycle for a load or load-reserved, and zero for a store or store-conditional.
- R4: Operation codes on `req_op` are 0 = load, 1 = store, 2 = load-reserved and 3 = store-conditional. A store writes its data, and a later load returns it.
- R5: A load-reserved followed by a store-conditional from the same requester to the same address, with no write to that address in between, writes the data and returns `rsp_ok` = 1. `rsp_ok` is 1 only for a successful store-conditional.
- R6: A store-conditional without a matching reservation leaves memory unchanged and returns `rsp_ok` = 0.
- R7: A store, or a successful store-conditional, from any requester clears every reservation on that address. Loads, and writes to other addresses, leave reservations intact.
- R8: An eviction pulse (`evict_vld`) clears every reservation on `evict_addr`. An eviction in the same cycle as a granted store-conditional to that address makes the store-conditional fail.
- R9: Each requester holds at most one reservation. A new load-reserved replaces the previous one.
- R10: A successful store-conditional clears the reservations of all requesters on its address. Any store-conditional, whether it passes or fails, drops the issuer's own reservation.
- R11: When several requests are pending in the same cycle, the lowest-numbered requester is granted first and the others wait. A write granted earlier in that order makes a later store-conditional to the same address fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_vld | input | NREQ | Request pending, one bit per requester |
| req_op | input | 2*NREQ | Operation code, two bits per requester |
| req_addr | input | AW*NREQ | Word address, per requester |
| req_wdata | input | DW*NREQ | Write data, per requester |
| gnt | output | NREQ | One-hot grant, combinational from `req_vld` |
| evict_vld | input | 1 | Eviction or invalidation pulse |
| evict_addr | input | AW | Address being evicted |
| rsp_vld | output | NREQ | Response strobe for the requester granted in the previous cycle |
| rsp_rdata | output | DW | Read data of the response |
| rsp_ok | output | 1 | Store-conditional success flag |

## Verification
The assertions assume that a requester keeps its request fields steady until it sees its grant, and then drops the request before the next edge unless it is issuing a new operation. They also assume that `evict_vld` lasts a single cycle. The bench drives every input at the falling edge, releases a request at the falling edge that follows its grant, and raises the eviction only together with the request it is meant to race. Under these conditions, each grant maps to exactly one response, which is the relation the response and store-conditional properties rely on.

// File: rtl/llsc_pkg.sv
// Package: shared operation codes for the reservation monitor.
// Assumes: operation field is two bits wide on every requester port.
package llsc_pkg;
    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_LR    = 2'd2,
        OP_SC    = 2'd3
    } op_e;
endpackage

// File: rtl/llsc_prio_arb.sv
// Module: fixed-priority arbiter, lowest index wins.
// Assumes: NREQ >= 2; request vector is stable for the cycle.
module llsc_prio_arb #(
    parameter int NREQ = 4,
    localparam int IW = $clog2(NREQ)
) (
    input  logic [NREQ-1:0] req,
    output logic [NREQ-1:0] gnt,
    output logic            any,
    output logic [IW-1:0]   idx
);
    // Scan from the top so the lowest set bit is left standing.
    always_comb begin
        gnt = '0;
        any = 1'b0;
        idx = '0;
        for (int i = NREQ - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                any    = 1'b1;
                idx    = IW'(i);
            end
        end
    end
endmodule

// File: rtl/llsc_word_mem.sv
// Module: register-based word memory, combinational read, one write port.
// Assumes: small depth; reset clears all words.
module llsc_word_mem #(
    parameter int DEPTH = 16,
    parameter int DW = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] words [DEPTH];

    // Clear on reset, otherwise commit the single write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) words[i] <= '0;
        end else if (we) begin
            words[addr] <= wdata;
        end
    end

    // Read returns the word as it stood before this cycle's write.
    always_comb rdata = words[addr];
endmodule

// File: rtl/llsc_rsv_table.sv
// Module: one reservation slot per requester, plus the store-conditional
// pass decision for the granted request.
// Assumes: at most one granted operation per cycle; eviction is applied
// before the granted operation of the same cycle.
module llsc_rsv_table #(
    parameter int NREQ = 4,
    parameter int AW = 4,
    localparam int IW = $clog2(NREQ)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire,
    input  logic [IW-1:0] g_idx,
    input  logic [1:0]    g_op,
    input  logic [AW-1:0] g_addr,
    input  logic          evict_vld,
    input  logic [AW-1:0] evict_addr,
    output logic          sc_pass,
    output logic          wr_commit
);
    import llsc_pkg::*;

    logic [NREQ-1:0] slot_v;
    logic [AW-1:0]   slot_a [NREQ];
    logic            ev_hits_g;

    // A same-cycle eviction of the target address defeats the pair.
    always_comb ev_hits_g = evict_vld && (evict_addr == g_addr);

    // Pass when the issuer's own slot still covers the target address.
    always_comb begin
        sc_pass = fire && (g_op == OP_SC) && slot_v[g_idx]
                  && (slot_a[g_idx] == g_addr) && !ev_hits_g;
        wr_commit = fire && ((g_op == OP_STORE) || sc_pass);
    end

    for (genvar j = 0; j < NREQ; j++) begin : g_slot
        logic own, clr_ev, clr_wr;

        // Decide which events touch slot j this cycle.
        always_comb begin
            own    = fire && (g_idx == IW'(j));
            clr_ev = evict_vld && (slot_a[j] == evict_addr);
            clr_wr = wr_commit && (slot_a[j] == g_addr);
        end

        // Set on own reserve, clear on eviction, write hit or own conditional.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_v[j] <= 1'b0;
                slot_a[j] <= '0;
            end else if (own && g_op == OP_LR) begin
                slot_v[j] <= 1'b1;
                slot_a[j] <= g_addr;
            end else if (clr_ev || clr_wr || (own && g_op == OP_SC)) begin
                slot_v[j] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/llsc_monitor.sv
// Module: shared word memory with a load-reserved / store-conditional
// monitor and a fixed-priority arbiter granting one request per cycle.
// Assumes: a requester holds its request until granted and drops it in
// the cycle after; responses arrive one cycle after the grant.
module llsc_monitor #(
    parameter int NREQ = 4,
    parameter int DEPTH = 16,
    parameter int DW = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NREQ-1:0]      req_vld,
    input  logic [2*NREQ-1:0]    req_op,
    input  logic [AW*NREQ-1:0]   req_addr,
    input  logic [DW*NREQ-1:0]   req_wdata,
    output logic [NREQ-1:0]      gnt,
    input  logic                 evict_vld,
    input  logic [AW-1:0]        evict_addr,
    output logic [NREQ-1:0]      rsp_vld,
    output logic [DW-1:0]        rsp_rdata,
    output logic                 rsp_ok
);
    import llsc_pkg::*;
    localparam int IW = $clog2(NREQ);

    logic          fire;
    logic [IW-1:0] g_idx;
    logic [1:0]    g_op;
    logic [AW-1:0] g_addr;
    logic [DW-1:0] g_wdata;
    logic [DW-1:0] mem_rd;
    logic          sc_pass, wr_commit;

    llsc_prio_arb #(.NREQ(NREQ)) u_arb (
        .req (req_vld),
        .gnt (gnt),
        .any (fire),
        .idx (g_idx)
    );

    // Select the fields of the granted requester.
    always_comb begin
        g_op    = '0;
        g_addr  = '0;
        g_wdata = '0;
        for (int i = 0; i < NREQ; i++) begin
            if (gnt[i]) begin
                g_op    = req_op[i*2 +: 2];
                g_addr  = req_addr[i*AW +: AW];
                g_wdata = req_wdata[i*DW +: DW];
            end
        end
    end

    llsc_rsv_table #(.NREQ(NREQ), .AW(AW)) u_rsv (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (fire),
        .g_idx      (g_idx),
        .g_op       (g_op),
        .g_addr     (g_addr),
        .evict_vld  (evict_vld),
        .evict_addr (evict_addr),
        .sc_pass    (sc_pass),
        .wr_commit  (wr_commit)
    );

    llsc_word_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_commit),
        .addr  (g_addr),
        .wdata (g_wdata),
        .rdata (mem_rd)
    );

    // Register the response of the granted operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_vld   <= '0;
            rsp_rdata <= '0;
            rsp_ok    <= 1'b0;
        end else begin
            rsp_vld   <= fire ? gnt : '0;
            rsp_rdata <= (fire && (g_op == OP_LOAD || g_op == OP_LR)) ? mem_rd : '0;
            rsp_ok    <= sc_pass;
        end
    end
endmodule

// File: rtl/llsc_monitor_chk.sv
// Module: property checker for llsc_monitor, attached by bind.
// Assumes: observes only the top-level ports.
module llsc_monitor_chk #(
    parameter int NREQ = 4,
    parameter int DEPTH = 16,
    parameter int DW = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NREQ-1:0]     req_vld,
    input logic [2*NREQ-1:0]   req_op,
    input logic [AW*NREQ-1:0]  req_addr,
    input logic [NREQ-1:0]     gnt,
    input logic                evict_vld,
    input logic [AW-1:0]       evict_addr,
    input logic [NREQ-1:0]     rsp_vld,
    input logic [DW-1:0]       rsp_rdata,
    input logic                rsp_ok
);
    import llsc_pkg::*;

    logic [1:0]    c_op;
    logic [AW-1:0] c_addr;
    logic          c_any;

    // Recover the granted operation from the grant and request ports.
    always_comb begin
        c_op   = '0;
        c_addr = '0;
        c_any  = |gnt;
        for (int i = 0; i < NREQ; i++) begin
            if (gnt[i]) begin
                c_op   = req_op[i*2 +: 2];
                c_addr = req_addr[i*AW +: AW];
            end
        end
    end

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt)); // R2
    AST_GNT_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req_vld) == '0); // R2
    AST_NO_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_vld) |-> (|gnt)); // R2
    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        c_any |-> (((gnt - 1'b1) & req_vld) == '0)); // R11
    AST_RSP_FOLLOWS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rsp_vld == $past(gnt))); // R3
    AST_WRITE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (c_any && (c_op == OP_STORE || c_op == OP_SC)) |=> (rsp_rdata == '0)); // R3
    AST_OK_ONLY_SC: assert property (@(posedge clk) disable iff (!rst_n)
        (c_any && c_op != OP_SC) |=> !rsp_ok); // R5
    AST_EVICT_BEATS_SC: assert property (@(posedge clk) disable iff (!rst_n)
        (evict_vld && c_any && c_op == OP_SC && c_addr == evict_addr) |=> !rsp_ok); // R8
endmodule

bind llsc_monitor llsc_monitor_chk #(.NREQ(NREQ), .DEPTH(DEPTH), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_vld    (req_vld),
    .req_op     (req_op),
    .req_addr   (req_addr),
    .gnt        (gnt),
    .evict_vld  (evict_vld),
    .evict_addr (evict_addr),
    .rsp_vld    (rsp_vld),
    .rsp_rdata  (rsp_rdata),
    .rsp_ok     (rsp_ok)
);

// File: tb/sim_llsc_monitor.sv
// Bench: directed scenarios for llsc_monitor, one task per scenario.
module sim_llsc_monitor;
    import llsc_pkg::*;
    localparam int N = 4;
    localparam int AW = 4;
    localparam int DW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    req_vld = '0;
    logic [2*N-1:0]  req_op = '0;
    logic [AW*N-1:0] req_addr = '0;
    logic [DW*N-1:0] req_wdata = '0;
    logic [N-1:0]    gnt;
    logic            evict_vld = 1'b0;
    logic [AW-1:0]   evict_addr = '0;
    logic [N-1:0]    rsp_vld;
    logic [DW-1:0]   rsp_rdata;
    logic            rsp_ok;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    llsc_monitor #(.NREQ(N), .DEPTH(16), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .gnt(gnt),
        .evict_vld(evict_vld), .evict_addr(evict_addr),
        .rsp_vld(rsp_vld), .rsp_rdata(rsp_rdata), .rsp_ok(rsp_ok)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic put(input int id, input op_e op, input int a, input logic [31:0] d);
        req_vld[id] = 1'b1;
        req_op[id*2 +: 2] = op;
        req_addr[id*AW +: AW] = a[AW-1:0];
        req_wdata[id*DW +: DW] = d;
    endtask

    // Issue one request alone; returns response fields one cycle later.
    task automatic issue(input int id, input op_e op, input int a, input logic [31:0] d,
                         input bit ev, input int ea,
                         output logic [31:0] rd, output logic ok);
        @(negedge clk);
        put(id, op, a, d);
        evict_vld = ev;
        evict_addr = ea[AW-1:0];
        @(negedge clk);
        req_vld[id] = 1'b0;
        evict_vld = 1'b0;
        check("R3 rsp_vld", 32'(rsp_vld), 32'(1 << id));
        rd = rsp_rdata;
        ok = rsp_ok;
    endtask

    task automatic t_reset();
        logic [31:0] rd; logic ok;
        check("R1 rsp_vld after reset", 32'(rsp_vld), 0);
        issue(0, OP_LOAD, 3, 0, 0, 0, rd, ok);
        check("R1 memory cleared", rd, 0);
        issue(0, OP_SC, 3, 32'h55, 0, 0, rd, ok);
        check("R1 sc without reserve fails", 32'(ok), 0);
        issue(1, OP_LOAD, 3, 0, 0, 0, rd, ok);
        check("R6 failed sc left memory", rd, 0);
        @(negedge clk);
        check("R3 rsp_vld one cycle", 32'(rsp_vld), 0);
    endtask

    task automatic t_load_store();
        logic [31:0] rd; logic ok;
        issue(1, OP_STORE, 5, 32'hA5A5_0001, 0, 0, rd, ok);
        check("R3 store rdata zero", rd, 0);
        check("R5 store rsp_ok zero", 32'(ok), 0);
        issue(2, OP_LOAD, 5, 0, 0, 0, rd, ok);
        check("R4 load returns stored", rd, 32'hA5A5_0001);
    endtask

    task automatic t_pair_ok();
        logic [31:0] rd; logic ok;
        issue(0, OP_STORE, 2, 32'h0000_0007, 0, 0, rd, ok);
        issue(0, OP_LR, 2, 0, 0, 0, rd, ok);
        check("R3 reserve returns word", rd, 32'h7);
        issue(1, OP_LOAD, 2, 0, 0, 0, rd, ok);
        issue(1, OP_STORE, 7, 32'h99, 0, 0, rd, ok);
        issue(0, OP_SC, 2, 32'h11, 0, 0, rd, ok);
        check("R7 unrelated traffic keeps pair", 32'(ok), 1);
        issue(2, OP_LOAD, 2, 0, 0, 0, rd, ok);
        check("R5 sc wrote data", rd, 32'h11);
    endtask

    task automatic t_foreign_write();
        logic [31:0] rd; logic ok;
        issue(0, OP_LR, 4, 0, 0, 0, rd, ok);
        issue(1, OP_STORE, 4, 32'h22, 0, 0, rd, ok);
        issue(0, OP_SC, 4, 32'h33, 0, 0, rd, ok);
        check("R7 foreign store breaks pair", 32'(ok), 0);
        issue(0, OP_LOAD, 4, 0, 0, 0, rd, ok);
        check("R6 failed sc memory unchanged", rd, 32'h22);
    endtask

    task automatic t_evict();
        logic [31:0] rd; logic ok;
        issue(1, OP_LR, 6, 0, 0, 0, rd, ok);
        issue(3, OP_LOAD, 0, 0, 1, 9, rd, ok);
        issue(1, OP_SC, 6, 32'h61, 0, 0, rd, ok);
        check("R8 other-address evict harmless", 32'(ok), 1);
        issue(1, OP_LR, 6, 0, 0, 0, rd, ok);
        issue(3, OP_LOAD, 0, 0, 1, 6, rd, ok);
        issue(1, OP_SC, 6, 32'h62, 0, 0, rd, ok);
        check("R8 evict clears reserve", 32'(ok), 0);
        issue(2, OP_LR, 8, 0, 0, 0, rd, ok);
        issue(2, OP_SC, 8, 32'h81, 1, 8, rd, ok);
        check("R8 same-cycle evict fails sc", 32'(ok), 0);
        issue(2, OP_LOAD, 8, 0, 0, 0, rd, ok);
        check("R8 memory unchanged", rd, 0);
    endtask

    task automatic t_replace();
        logic [31:0] rd; logic ok;
        issue(0, OP_LR, 1, 0, 0, 0, rd, ok);
        issue(0, OP_LR, 3, 0, 0, 0, rd, ok);
        issue(0, OP_SC, 1, 32'h10, 0, 0, rd, ok);
        check("R9 older reserve replaced", 32'(ok), 0);
    endtask

    task automatic t_sc_clears();
        logic [31:0] rd; logic ok;
        issue(0, OP_LR, 10, 0, 0, 0, rd, ok);
        issue(1, OP_LR, 10, 0, 0, 0, rd, ok);
        issue(1, OP_SC, 10, 32'hB1, 0, 0, rd, ok);
        check("R10 first sc passes", 32'(ok), 1);
        issue(0, OP_SC, 10, 32'hB0, 0, 0, rd, ok);
        check("R10 peer reserve cleared", 32'(ok), 0);
        issue(2, OP_LR, 11, 0, 0, 0, rd, ok);
        issue(2, OP_SC, 12, 32'hC0, 0, 0, rd, ok);
        check("R6 wrong address fails", 32'(ok), 0);
        issue(2, OP_SC, 11, 32'hC1, 0, 0, rd, ok);
        check("R10 failed sc drops own reserve", 32'(ok), 0);
    endtask

    task automatic t_same_cycle();
        logic [31:0] rd;
        issue(0, OP_LR, 12, 0, 0, 0, rd, rsp_ok_dummy);
        issue(3, OP_LR, 12, 0, 0, 0, rd, rsp_ok_dummy);
        @(negedge clk);
        put(0, OP_SC, 12, 32'hD0);
        put(3, OP_SC, 12, 32'hD3);
        #1;
        check("R11 lowest index granted", 32'(gnt), 32'b0001);
        @(negedge clk);
        req_vld[0] = 1'b0;
        check("R11 first sc passes", 32'(rsp_ok), 1);
        check("R3 response to first", 32'(rsp_vld), 32'b0001);
        #1;
        check("R2 waiting requester granted", 32'(gnt), 32'b1000);
        @(negedge clk);
        req_vld[3] = 1'b0;
        check("R11 later sc invalidated", 32'(rsp_ok), 0);
        check("R3 response to second", 32'(rsp_vld), 32'b1000);
        issue(1, OP_LOAD, 12, 0, 0, 0, rd, rsp_ok_dummy);
        check("R11 memory holds first write", rd, 32'hD0);
    endtask

    logic rsp_ok_dummy;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load_store();
        t_pair_ok();
        t_foreign_write();
        t_evict();
        t_replace();
        t_sc_clears();
        t_same_cycle();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule